// File: doc/BRIEF.md
# I2C Register Transaction Sequencer

This block drives an I2C bit engine through complete register transactions on a device with a 7-bit address. A caller asks for a write or a read by giving a device address, a register index and a byte count. The sequencer then issues start, stop, send-byte and receive-byte commands to the engine, one at a time, and waits for each to complete. Write bytes are pulled from the caller through a request/valid handshake. Read bytes are handed back through a one-cycle strobe. A status code is reported with a one-cycle done pulse.

An address phase that is not acknowledged is retried after a fixed gap, up to a parameterised number of attempts. A register read closes the index write with a full stop before it opens the read phase. After a write, the sequencer polls the device with address probes until the device's internal write cycle ends. The number of probes is capped, and exceeding the cap gives its own status. Bus timing is left to the bit engine.

Top module: `i2c_reg_seq`

## Requirements
- R1: Engine commands are encoded on `cmd_op` as 0 = start, 1 = stop, 2 = send `cmd_byte`, 3 = receive. `cmd_valid` is a one-cycle pulse. No new command is issued until `eng_done` has returned for the previous one. An address byte is `{dev, rw}`, with rw = 0 for write and 1 for read.
- R2: An address phase is a start followed by the address byte. On a not-acknowledge the sequencer waits `RETRY_GAP` cycles (the next start reaches the engine `RETRY_GAP`+1 cycles after the failing `eng_done`) and repeats the phase. After `MAX_TRIES` failed attempts it finishes with status 1 and issues no stop.
- R3: A write sends the register byte and then `len` data bytes in order. Each data byte is taken while `wr_req` and `wr_valid` are both high. `wr_req` stays high until a byte is offered.
- R4: A not-acknowledge on the register byte of a write finishes with status 3. No stop or poll follows.
- R5: A not-acknowledge on a write data byte ends the data loop. No further bytes are requested. A stop and the completion poll follow as usual.
- R6: After the write stop, the completion poll repeats this cycle until the write address is acknowledged: wait `POLL_GAP` cycles, start, write address; on a not-acknowledge, stop. The sequencer then sends two 0x00 bytes, a stop, a start and the write address, and finishes with status 0.
- R7: If the poll address is not acknowledged `POLL_MAX` times, the sequencer issues the stop that follows the last probe and finishes with status 4.
- R8: A read sends the write address, then the register byte, then a stop. It then runs a retried read-address phase and `len` receives. Each receive carries `cmd_byte[0]` = 1 (no acknowledge) only on the last byte. A stop follows, and the sequencer finishes with status 0. Each received byte appears once on `rd_data` with `rd_valid`.
- R9: A not-acknowledge on the register byte of a read finishes with status 1.
- R10: A read with `len` = 0 issues no command and raises `done` with status 2 in the cycle after the request.
- R11: `busy` is high from the cycle after an accepted request through the cycle of `done`, and low in the cycle after. `done` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_read | input | 1 | 1 = register read, 0 = register write |
| req_dev | input | 7 | Device address |
| req_reg | input | 8 | Register index |
| req_len | input | LEN_W | Number of data bytes |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction strobe |
| status | output | 3 | Result code, valid with done |
| wr_req | output | 1 | Sequencer wants the next write byte |
| wr_valid | input | 1 | Write byte offered |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| cmd_valid | output | 1 | Command strobe to bit engine |
| cmd_op | output | 2 | Command code |
| cmd_byte | output | 8 | Send byte, or no-acknowledge flag in bit 0 for receive |
| eng_done | input | 1 | Engine finished the command |
| eng_nack | input | 1 | Sent byte was not acknowledged |
| eng_rdata | input | 8 | Received byte |

## Verification
A new command reaches the engine one cycle after the `eng_done` that closes the previous one. After a failed address it arrives `RETRY_GAP`+1 cycles later, and after a poll stop `POLL_GAP`+1 cycles later. The engine model stamps every command with its distance from the last `eng_done`, and the bench compares those distances exactly. `done` for a zero-length read is due one cycle after the request, and `busy` one cycle after acceptance. Every other result is compared against a command log, which the bench builds together with the acknowledge plan it feeds back. All sampling is on the falling edge, so each registered output is read half a cycle after the edge that set it.

// File: rtl/i2c_reg_seq.sv
module i2c_reg_seq #(
  parameter int LEN_W     = 8,
  parameter int MAX_TRIES = 10,
  parameter int RETRY_GAP = 60000,
  parameter int POLL_GAP  = 5000,
  parameter int POLL_MAX  = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_read,
  input  logic [6:0]       req_dev,
  input  logic [7:0]       req_reg,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             done,
  output logic [2:0]       status,
  output logic             wr_req,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             cmd_valid,
  output logic [1:0]       cmd_op,
  output logic [7:0]       cmd_byte,
  input  logic             eng_done,
  input  logic             eng_nack,
  input  logic [7:0]       eng_rdata
);
  localparam int GMAX  = (RETRY_GAP > POLL_GAP) ? RETRY_GAP : POLL_GAP;
  localparam int GAP_W = $clog2(GMAX + 1);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam int PC_W  = $clog2(POLL_MAX + 1);
  localparam logic [1:0] OP_START = 2'd0, OP_STOP = 2'd1, OP_SEND = 2'd2, OP_RECV = 2'd3;
  localparam logic [2:0] ST_OK = 3'd0, ST_ADDR = 3'd1, ST_ZERO = 3'd2, ST_WREG = 3'd3, ST_POLL = 3'd4;

  typedef enum logic [4:0] {
    S_IDLE, S_START, S_ADDR, S_RGAP, S_REG, S_FETCH, S_WDATA, S_WSTOP,
    S_PGAP, S_PSTART, S_PADDR, S_PSTOP, S_Z1, S_Z2, S_FSTOP, S_FSTART,
    S_FADDR, S_RSTOP, S_RECV, S_ESTOP, S_DONE
  } state_t;

  state_t           state;
  logic             waiting, rd_mode, rd_phase;
  logic [6:0]       dev;
  logic [7:0]       regi, wbuf;
  logic [LEN_W-1:0] len, cnt;
  logic [TRY_W-1:0] tries;
  logic [PC_W-1:0]  pcnt;
  logic [GAP_W-1:0] gcnt;
  logic             is_cmd, last;

  assign busy   = (state != S_IDLE);
  assign done   = (state == S_DONE);
  assign wr_req = (state == S_FETCH);
  assign last   = (cnt == len - LEN_W'(1));

  always_comb begin
    is_cmd   = 1'b1;
    cmd_op   = OP_SEND;
    cmd_byte = 8'h00;
    case (state)
      S_START, S_PSTART, S_FSTART:            cmd_op = OP_START;
      S_WSTOP, S_PSTOP, S_FSTOP, S_RSTOP,
      S_ESTOP:                                cmd_op = OP_STOP;
      S_ADDR:                                 cmd_byte = {dev, rd_phase};
      S_PADDR, S_FADDR:                       cmd_byte = {dev, 1'b0};
      S_REG:                                  cmd_byte = regi;
      S_WDATA:                                cmd_byte = wbuf;
      S_Z1, S_Z2:                             cmd_byte = 8'h00;
      S_RECV: begin cmd_op = OP_RECV; cmd_byte = {7'd0, last}; end
      default:                                is_cmd = 1'b0;
    endcase
  end

  assign cmd_valid = is_cmd && !waiting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; waiting <= 1'b0; rd_mode <= 1'b0; rd_phase <= 1'b0;
      dev <= '0; regi <= '0; wbuf <= '0; len <= '0; cnt <= '0;
      tries <= '0; pcnt <= '0; gcnt <= '0; status <= ST_OK;
      rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (cmd_valid) waiting <= 1'b1;
      case (state)
        S_IDLE: if (req_valid) begin
          dev <= req_dev; regi <= req_reg; len <= req_len; rd_mode <= req_read;
          cnt <= '0; tries <= '0; pcnt <= '0; rd_phase <= 1'b0;
          if (req_read && req_len == '0) begin status <= ST_ZERO; state <= S_DONE; end
          else state <= S_START;
        end
        S_FETCH: if (wr_valid) begin wbuf <= wr_data; state <= S_WDATA; end
        S_RGAP: if (gcnt == '0) state <= S_START; else gcnt <= gcnt - GAP_W'(1);
        S_PGAP: if (gcnt == '0) state <= S_PSTART; else gcnt <= gcnt - GAP_W'(1);
        S_DONE: state <= S_IDLE;
        default: if (waiting && eng_done) begin
          waiting <= 1'b0;
          case (state)
            S_START:  state <= S_ADDR;
            S_ADDR:
              if (!eng_nack) state <= rd_phase ? S_RECV : S_REG;
              else if (tries == TRY_W'(MAX_TRIES - 1)) begin status <= ST_ADDR; state <= S_DONE; end
              else begin tries <= tries + TRY_W'(1); gcnt <= GAP_W'(RETRY_GAP - 1); state <= S_RGAP; end
            S_REG:
              if (eng_nack) begin status <= rd_mode ? ST_ADDR : ST_WREG; state <= S_DONE; end
              else if (rd_mode) state <= S_RSTOP;
              else state <= (len == '0) ? S_WSTOP : S_FETCH;
            S_WDATA:
              if (eng_nack || last) state <= S_WSTOP;
              else begin cnt <= cnt + LEN_W'(1); state <= S_FETCH; end
            S_WSTOP:  begin gcnt <= GAP_W'(POLL_GAP - 1); state <= S_PGAP; end
            S_PSTART: state <= S_PADDR;
            S_PADDR:
              if (!eng_nack) state <= S_Z1;
              else begin pcnt <= pcnt + PC_W'(1); state <= S_PSTOP; end
            S_PSTOP:
              if (pcnt == PC_W'(POLL_MAX)) begin status <= ST_POLL; state <= S_DONE; end
              else begin gcnt <= GAP_W'(POLL_GAP - 1); state <= S_PGAP; end
            S_Z1:     state <= S_Z2;
            S_Z2:     state <= S_FSTOP;
            S_FSTOP:  state <= S_FSTART;
            S_FSTART: state <= S_FADDR;
            S_FADDR:  begin status <= ST_OK; state <= S_DONE; end
            S_RSTOP:  begin rd_phase <= 1'b1; tries <= '0; state <= S_START; end
            S_RECV: begin
              rd_valid <= 1'b1; rd_data <= eng_rdata;
              if (last) state <= S_ESTOP; else cnt <= cnt + LEN_W'(1);
            end
            S_ESTOP:  begin status <= ST_OK; state <= S_DONE; end
            default:  state <= S_IDLE;
          endcase
        end
      endcase
    end
  end

  // R1
  cmd_once_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |=> !cmd_valid);
  // R2
  tries_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) tries < TRY_W'(MAX_TRIES));
  // R3
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (wr_req && !wr_valid) |=> wr_req);
  // R7
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) pcnt <= PC_W'(POLL_MAX));
  // R8
  rd_in_txn_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> (busy && rd_mode));
  // R10
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_read && req_len == '0) |=> (done && status == ST_ZERO));
  // R11
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
endmodule

// File: tb/i2c_reg_seq_tb_top.sv
module i2c_reg_seq_tb_top;
  localparam int RG = 20, PG = 10, PM = 4, MT = 10;
  localparam logic [6:0] DEV = 7'h2A;
  localparam logic [7:0] AW = {DEV, 1'b0}, AR = {DEV, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_read = 0;
  logic [6:0] req_dev = DEV;
  logic [7:0] req_reg = 0, req_len = 0;
  logic busy, done, wr_req, rd_valid, cmd_valid;
  logic [2:0] status;
  logic wr_valid = 0;
  logic [7:0] wr_data = 0, rd_data, cmd_byte;
  logic [1:0] cmd_op;
  logic eng_done = 0, eng_nack = 0;
  logic [7:0] eng_rdata = 0;

  i2c_reg_seq #(.LEN_W(8), .MAX_TRIES(MT), .RETRY_GAP(RG), .POLL_GAP(PG), .POLL_MAX(PM)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read), .req_dev(req_dev),
    .req_reg(req_reg), .req_len(req_len), .busy(busy), .done(done), .status(status),
    .wr_req(wr_req), .wr_valid(wr_valid), .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
    .eng_done(eng_done), .eng_nack(eng_nack), .eng_rdata(eng_rdata));

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nvec = 0, nfail = 0;
  int lg_n, ex_n, sidx, ridx, wcnt, rd_n, last_done;
  logic [1:0] lg_op [64];
  logic [7:0] lg_b [64];
  int         lg_dt [64];
  logic [1:0] ex_op [64];
  logic [7:0] ex_b [64];
  logic       nplan [64];
  logic [7:0] rd_buf [16];
  logic got_done;
  logic [2:0] got_st;

  task automatic check(string r, int act, int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  initial begin
    int pend;
    logic nk; logic [7:0] rb;
    pend = 0;
    forever begin
      @(negedge clk);
      if (eng_done) eng_done = 0;
      if (cmd_valid) begin
        if (lg_n < 64) begin
          lg_op[lg_n] = cmd_op; lg_b[lg_n] = cmd_byte; lg_dt[lg_n] = cyc - last_done;
        end
        lg_n++;
        nk = 0; rb = 0;
        if (cmd_op == 2'd2) begin nk = (sidx < 64) ? nplan[sidx] : 1'b0; sidx++; end
        if (cmd_op == 2'd3) begin rb = 8'hA0 + 8'(ridx); ridx++; end
        pend = 2;
      end else if (pend > 0) begin
        pend--;
        if (pend == 0) begin eng_done = 1; eng_nack = nk; eng_rdata = rb; last_done = cyc; end
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (wr_valid) wr_valid = 0;
    else if (wr_req) begin wr_valid = 1; wr_data = 8'h50 + 8'(wcnt); wcnt++; end
    if (rd_valid) begin if (rd_n < 16) rd_buf[rd_n] = rd_data; rd_n++; end
    if (done) begin got_done = 1; got_st = status; end
  end

  task automatic clear();
    lg_n = 0; ex_n = 0; sidx = 0; ridx = 0; wcnt = 0; rd_n = 0; got_done = 0;
    for (int i = 0; i < 64; i++) nplan[i] = 0;
  endtask

  task automatic e(logic [1:0] op, logic [7:0] b);
    ex_op[ex_n] = op; ex_b[ex_n] = b; ex_n++;
  endtask

  task automatic es(logic [7:0] b, logic nk);
    e(2'd2, b); nplan[sidx] = nk; sidx++;
  endtask

  task automatic poll_tail(int nacks);
    for (int k = 0; k < nacks; k++) begin e(2'd0, 0); es(AW, 1); e(2'd1, 0); end
    e(2'd0, 0); es(AW, 0); es(8'h00, 0); es(8'h00, 0); e(2'd1, 0); e(2'd0, 0); es(AW, 0);
  endtask

  task automatic run(logic rd, logic [7:0] rg, logic [7:0] ln, string r);
    int t;
    sidx = 0;
    @(negedge clk);
    req_read = rd; req_reg = rg; req_len = ln; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    // R11: busy from the cycle after acceptance
    check({r, "/R11 busy"}, int'(busy), 1);
    t = 0;
    while (!got_done && t < 20000) begin @(negedge clk); t++; end
    if (!got_done) check({r, " done timeout"}, 0, 1);
    @(negedge clk);
    check({r, "/R11 idle after done"}, int'(busy), 0);
  endtask

  task automatic cmp_log(string r);
    check({r, " cmd count"}, lg_n, ex_n);
    for (int i = 0; i < ex_n && i < lg_n; i++) begin
      check({r, " cmd op"}, int'(lg_op[i]), int'(ex_op[i]));
      check({r, " cmd byte"}, int'(lg_b[i]), int'(ex_b[i]));
    end
  endtask

  task automatic t_reset();
    check("R11 reset busy", int'(busy), 0);
    check("R11 reset done", int'(done), 0);
    check("R1 reset cmd_valid", int'(cmd_valid), 0);
  endtask

  task automatic t_write_plain();
    clear();
    e(0, 0); es(AW, 0); es(8'h11, 0); es(8'h50, 0); es(8'h51, 0); e(1, 0); poll_tail(0);
    run(0, 8'h11, 2, "R3");
    check("R6 status", int'(got_st), 0);
    cmp_log("R3/R6 write");
    check("R6 poll gap", lg_dt[6], PG + 1);
    check("R3 bytes taken", wcnt, 2);
  endtask

  task automatic t_write_retry();
    clear();
    e(0, 0); es(AW, 1); e(0, 0); es(AW, 1); e(0, 0); es(AW, 0); es(8'h22, 0); es(8'h50, 0); e(1, 0);
    poll_tail(0);
    run(0, 8'h22, 1, "R2");
    check("R2 status", int'(got_st), 0);
    cmp_log("R2 retry");
    check("R2 retry gap", lg_dt[2], RG + 1);
    check("R1 no gap", lg_dt[1], 1);
  endtask

  task automatic t_addr_fail();
    clear();
    for (int k = 0; k < MT; k++) begin e(0, 0); es(AW, 1); end
    run(0, 8'h33, 1, "R2");
    check("R2 exhaust status", int'(got_st), 1);
    cmp_log("R2 exhaust");
  endtask

  task automatic t_wreg_nack();
    clear();
    e(0, 0); es(AW, 0); es(8'h44, 1);
    run(0, 8'h44, 2, "R4");
    check("R4 status", int'(got_st), 3);
    cmp_log("R4 log");
    check("R4 no byte taken", wcnt, 0);
  endtask

  task automatic t_data_nack();
    clear();
    e(0, 0); es(AW, 0); es(8'h55, 0); es(8'h50, 0); es(8'h51, 1); e(1, 0); poll_tail(0);
    run(0, 8'h55, 3, "R5");
    check("R5 status", int'(got_st), 0);
    cmp_log("R5 log");
    check("R5 bytes taken", wcnt, 2);
  endtask

  task automatic t_poll_nack();
    clear();
    e(0, 0); es(AW, 0); es(8'h66, 0); es(8'h50, 0); e(1, 0); poll_tail(2);
    run(0, 8'h66, 1, "R6");
    check("R6 status", int'(got_st), 0);
    cmp_log("R6 log");
    check("R6 gap after poll stop", lg_dt[8], PG + 1);
  endtask

  task automatic t_poll_timeout();
    clear();
    e(0, 0); es(AW, 0); es(8'h77, 0); es(8'h50, 0); e(1, 0);
    for (int k = 0; k < PM; k++) begin e(0, 0); es(AW, 1); e(1, 0); end
    run(0, 8'h77, 1, "R7");
    check("R7 status", int'(got_st), 4);
    cmp_log("R7 log");
  endtask

  task automatic t_read(int rnack);
    clear();
    e(0, 0); es(AW, 0); es(8'h88, 0); e(1, 0);
    for (int k = 0; k < rnack; k++) begin e(0, 0); es(AR, 1); end
    e(0, 0); es(AR, 0); e(3, 0); e(3, 0); e(3, 1); e(1, 0);
    run(1, 8'h88, 3, "R8");
    check("R8 status", int'(got_st), 0);
    cmp_log("R8 log");
    check("R8 byte count", rd_n, 3);
    for (int i = 0; i < 3 && i < rd_n; i++) check("R8 read byte", int'(rd_buf[i]), 'hA0 + i);
  endtask

  task automatic t_rreg_nack();
    clear();
    e(0, 0); es(AW, 0); es(8'h99, 1);
    run(1, 8'h99, 2, "R9");
    check("R9 status", int'(got_st), 1);
    cmp_log("R9 log");
    check("R9 no read byte", rd_n, 0);
  endtask

  task automatic t_zero_read();
    clear();
    @(negedge clk);
    req_read = 1; req_reg = 8'hAA; req_len = 0; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    check("R10 done next cycle", int'(done), 1);
    check("R10 status", int'(status), 2);
    check("R11 busy with done", int'(busy), 1);
    repeat (5) @(negedge clk);
    check("R10 no commands", lg_n, 0);
    check("R11 idle", int'(busy), 0);
  endtask

  initial begin
    #(200000 * 10);
    nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    last_done = 0;
    clear();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_write_plain();
    t_write_retry();
    t_addr_fail();
    t_wreg_nack();
    t_data_nack();
    t_poll_nack();
    t_poll_timeout();
    t_read(0);
    t_read(1);
    t_rreg_nack();
    t_zero_read();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule